// File: doc/BRIEF.md
# Commit-or-Discard Frame Reassembly Buffer

This block sits on the receive output of a preemption reassembly stage. Beats of a preemptable frame reach it one at a time, fragment after fragment, with no way to stall the source. The block stores the beats in a small single-clock buffer and releases nothing to its AXI4-Stream master until the frame's final beat arrives with a clean status. A frame closed with its error flag set is thrown away as a whole. So is a frame that runs out of room partway through.

Two write pointers track the buffer. A committed pointer marks the end of the frames that are released. A speculative pointer advances with every stored beat. A clean end of frame moves the committed pointer up to the speculative one. An error or an overflow pulls the speculative pointer back to the committed one, which erases everything written for that frame. After an overflow, the remaining beats of the frame are ignored up to and including its final beat. Every overflow raises a one-cycle drop pulse and advances a drop counter that saturates at its maximum value.

Top module: `frag_commit_fifo`

## Requirements
- R1: After reset, `m_tvalid` is 0, `drop_pulse` is 0 and `drop_count` is 0.
- R2: While a frame is being written, `m_tvalid` remains at the value it had before the frame began, so no beat of an uncommitted frame is ever visible.
- R3: A frame whose final beat (`in_last`=1) carries `in_err`=0 and fits in the buffer is output with its data in arrival order. `m_tlast`=1 is set on its final beat only. `m_tvalid` rises in the cycle after the edge that captures the final input beat, when the buffer was empty.
- R4: While `m_tready` is held at 1, a released frame is output on consecutive cycles from its first beat to its last, with no cycle of `m_tvalid`=0 between them.
- R5: A frame whose final beat carries `in_err`=1 produces no output. It leaves `drop_count` unchanged and raises no `drop_pulse`. The space it used is free for the next frame.
- R6: A beat that arrives when stored-but-unread beats, committed or not, number DEPTH is an overflow. The whole frame is discarded, `drop_pulse` is 1 for exactly one cycle (the cycle after that beat's edge), and `drop_count` increases by one. Overflow takes precedence over `in_err`.
- R7: After an overflow, the later beats of the same frame are ignored through its final beat. They cause no further drops, and the next frame is handled normally.
- R8: `drop_count` stays at its all-ones value once it gets there.
- R9: While `m_tvalid`=1 and `m_tready`=0, the next cycle keeps `m_tvalid`=1 with unchanged `m_tdata` and `m_tlast`. Frames committed earlier are never affected by later drops.
- R10: With an empty buffer, a clean frame of exactly DEPTH beats is accepted and output in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input beat is present this cycle |
| in_data | input | DATA_W | Input beat data |
| in_last | input | 1 | Final beat of the frame |
| in_err | input | 1 | With in_last: 1 = reassembly failed |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tdata | output | DATA_W | Output beat data |
| m_tlast | output | 1 | Final beat of the released frame |
| drop_pulse | output | 1 | One-cycle pulse per overflow drop |
| drop_count | output | CNT_W | Saturating count of overflow drops |

## Verification
Single frames are swept through every length from 1 to DEPTH+3, each closed both cleanly and with an error. This separates the accept, reject and overflow paths, and the DEPTH-beat boundary from the DEPTH+1 case. A second sweep keeps one committed frame of every length in the buffer while a second frame of every length arrives. This places the overflow point at each possible position and shows that a drop never damages the frame already released. Draining uses an always-ready pattern to expose gaps inside a frame, and two stalling patterns to expose data that moves while it is held.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
    typedef enum logic {
        WR_ACCEPT  = 1'b0,
        WR_SWALLOW = 1'b1
    } wr_mode_e;
endpackage

// File: rtl/fcf_wr_ctrl.sv
module fcf_wr_ctrl
    import fcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PTR_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_err,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [PTR_W-1:0] commit_ptr,
    output logic             drop_evt,
    output logic             drop_pulse
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] ws;
        logic [PTR_W-1:0] wc;
        wr_mode_e         mode;
        logic             pulse;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic [PTR_W-1:0] used;

    always_comb begin
        s_d      = s_q;
        s_d.pulse = 1'b0;
        mem_we   = 1'b0;
        drop_evt = 1'b0;
        used     = s_q.ws - rd_ptr;
        if (in_valid) begin
            if (s_q.mode == WR_SWALLOW) begin
                if (in_last) s_d.mode = WR_ACCEPT;
            end else if (used == DEPTH_P) begin
                drop_evt  = 1'b1;
                s_d.pulse = 1'b1;
                s_d.ws    = s_q.wc;
                if (!in_last) s_d.mode = WR_SWALLOW;
            end else begin
                mem_we = 1'b1;
                s_d.ws = s_q.ws + 1'b1;
                if (in_last) begin
                    if (in_err) s_d.ws = s_q.wc;
                    else        s_d.wc = s_q.ws + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ws    <= '0;
            s_q.wc    <= '0;
            s_q.mode  <= WR_ACCEPT;
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_waddr  = s_q.ws[AW-1:0];
    assign commit_ptr = s_q.wc;
    assign drop_pulse = s_q.pulse;

    // R6: occupancy never exceeds the storage
    p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(s_q.ws - rd_ptr) <= DEPTH_P));
    // R2: committed end never passes the speculative end
    p_commit_behind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(s_q.wc - rd_ptr) <= PTR_W'(s_q.ws - rd_ptr)));
    // R6: each overflow event shows up as a pulse next cycle
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> drop_pulse);
    // R7: while swallowing, nothing speculative is held
    p_swallow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WR_SWALLOW) |-> (s_q.ws == s_q.wc));
    // R5: an errored end rewinds without moving the commit point
    p_err_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s_q.mode == WR_ACCEPT && in_last && in_err)
        |=> (s_q.ws == s_q.wc) && $stable(s_q.wc));
endmodule

// File: rtl/fcf_store.sv
module fcf_store #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 9,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fcf_rd_ctrl.sv
module fcf_rd_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PTR_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] commit_ptr,
    input  logic             m_tready,
    output logic             m_tvalid,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [AW-1:0]    raddr
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        m_tvalid = (s_q.rd != commit_ptr);
        if (m_tvalid && m_tready) s_d.rd = s_q.rd + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.rd <= '0;
        else        s_q    <= s_d;
    end

    assign rd_ptr = s_q.rd;
    assign raddr  = s_q.rd[AW-1:0];

    // R9: a stalled beat keeps its slot
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> m_tvalid && $stable(s_q.rd));
endmodule

// File: rtl/fcf_drop_ctr.sv
module fcf_drop_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_evt,
    output logic [CNT_W-1:0] drop_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (drop_evt && s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.cnt <= '0;
        else        s_q     <= s_d;
    end

    assign drop_count = s_q.cnt;

    // R8: saturated count holds
    p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));
    // R6: one step per overflow below saturation
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_evt && drop_count != CNT_MAX)
        |=> (drop_count == CNT_W'($past(drop_count) + 1'b1)));
    // R5: no event, no change
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_evt |=> $stable(drop_count));
endmodule

// File: rtl/frag_commit_fifo.sv
module frag_commit_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              drop_pulse,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;
    localparam int ENT_W = DATA_W + 1;

    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [AW-1:0]    mem_raddr;
    logic [PTR_W-1:0] commit_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             drop_evt;
    logic [ENT_W-1:0] rd_entry;

    fcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_err     (in_err),
        .rd_ptr     (rd_ptr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .commit_ptr (commit_ptr),
        .drop_evt   (drop_evt),
        .drop_pulse (drop_pulse)
    );

    fcf_store #(.DEPTH(DEPTH), .WIDTH(ENT_W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata ({in_last, in_data}),
        .raddr (mem_raddr),
        .rdata (rd_entry)
    );

    fcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_ptr (commit_ptr),
        .m_tready   (m_tready),
        .m_tvalid   (m_tvalid),
        .rd_ptr     (rd_ptr),
        .raddr      (mem_raddr)
    );

    fcf_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop_evt   (drop_evt),
        .drop_count (drop_count)
    );

    assign m_tdata = rd_entry[DATA_W-1:0];
    assign m_tlast = rd_entry[DATA_W];

    // R4: a released frame streams without gaps under constant ready
    p_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !m_tlast) |=> m_tvalid);
    // R9: held beat keeps its payload
    p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> $stable(m_tdata) && $stable(m_tlast));
endmodule

// File: tb/tb_frag_commit_fifo.sv
module tb_frag_commit_fifo;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = 3;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_err = 1'b0;
    logic              m_tvalid;
    logic              m_tready = 1'b0;
    logic [DATA_W-1:0] m_tdata;
    logic              m_tlast;
    logic              drop_pulse;
    logic [CNT_W-1:0]  drop_count;

    int nvec = 0;
    int nfail = 0;
    int drops = 0;
    int occ = 0;
    bit done = 1'b0;
    int exp_data[$];
    bit exp_last[$];

    always #2 clk = ~clk;

    frag_commit_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input int len, input int base, input bit err);
        int pulses = 0;
        bit vis_bad = 1'b0;
        bit exp_vis = (occ > 0);
        bit ovf = (occ + len > DEPTH);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0 && drop_pulse) pulses++;
            if (m_tvalid != exp_vis) vis_bad = 1'b1;
            in_valid = 1'b1;
            in_data  = DATA_W'(base + i);
            in_last  = (i == len - 1);
            in_err   = (i == len - 1) ? err : 1'b0;
        end
        @(negedge clk);
        if (drop_pulse) pulses++;
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        if (ovf) begin
            drops++;
        end else if (!err) begin
            for (int i = 0; i < len; i++) begin
                exp_data.push_back((base + i) & 8'hFF);
                exp_last.push_back(i == len - 1);
            end
            occ += len;
        end
        @(negedge clk);
        if (drop_pulse) pulses++;
        chk(!vis_bad, "R2", "tvalid during write", int'(vis_bad), 0);
        chk(pulses == (ovf ? 1 : 0), ovf ? "R6" : "R5", "drop pulses", pulses, ovf ? 1 : 0);
        chk(int'(drop_count) == (drops > CMAX ? CMAX : drops), drops > CMAX ? "R8" : "R6",
            "drop_count", int'(drop_count), drops > CMAX ? CMAX : drops);
        chk(m_tvalid == (occ > 0), "R3", "tvalid after frame end", int'(m_tvalid), int'(occ > 0));
    endtask

    task automatic drain(input int mode);
        int cyc = 0;
        bit held = 1'b0;
        bit inframe = 1'b0;
        bit rdy;
        logic [DATA_W-1:0] pdata = '0;
        logic plast = 1'b0;
        while (exp_data.size() > 0 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (held)
                chk(m_tvalid && m_tdata == pdata && m_tlast == plast, "R9", "held beat changed",
                    int'(m_tdata), int'(pdata));
            if (mode == 0 && inframe)
                chk(m_tvalid, "R4", "gap inside frame", int'(m_tvalid), 1);
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 3) != 0);
            if (m_tvalid && rdy) begin
                chk(int'(m_tdata) == exp_data[0], "R3", "data", int'(m_tdata), exp_data[0]);
                chk(m_tlast == exp_last[0], "R3", "tlast", int'(m_tlast), int'(exp_last[0]));
                inframe = !m_tlast;
                void'(exp_data.pop_front());
                void'(exp_last.pop_front());
            end
            held = m_tvalid && !rdy;
            pdata = m_tdata;
            plast = m_tlast;
            m_tready = rdy;
        end
        @(negedge clk);
        m_tready = 1'b0;
        chk(exp_data.size() == 0, "R3", "beats left undelivered", exp_data.size(), 0);
        exp_data.delete();
        exp_last.delete();
        occ = 0;
        repeat (2) begin
            @(negedge clk);
            chk(!m_tvalid, "R5", "extra output beat", int'(m_tvalid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!m_tvalid, "R1", "reset tvalid", int'(m_tvalid), 0);
        chk(!drop_pulse, "R1", "reset drop_pulse", int'(drop_pulse), 0);
        chk(drop_count == 0, "R1", "reset drop_count", int'(drop_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 boundary at DEPTH, R6/R7 beyond it, R5 with error end
        for (int len = 1; len <= DEPTH + 3; len++) begin
            for (int e = 0; e < 2; e++) begin
                send_frame(len, len * 16 + e, e[0]);
                drain(len % 3);
            end
        end

        // R9 earlier frame survives a later drop; R7 next frame after swallow
        for (int a = 1; a <= DEPTH; a++) begin
            for (int b = 1; b <= DEPTH; b++) begin
                send_frame(a, a * 7, 1'b0);
                send_frame(b, 100 + b * 5, 1'b0);
                drain((a + b) % 3);
            end
        end

        // R8 saturation after many drops
        chk(drops > CMAX && int'(drop_count) == CMAX, "R8", "saturated count",
            int'(drop_count), CMAX);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule